// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and control flags of a small processor core and decides, every clock, how each flag changes. The execution unit hands it a byte of freshly computed flag values together with a byte mask. Only the flags selected by the mask are updated. Separate strobes handle the global interrupt enable, the transfer bit and direct byte-wide writes. The current flags come out as one byte, which also serves as the read value of the register's I/O location.

The sign flag is never stored on its own. It is always the exclusive OR of the negative and overflow flags, whatever path last changed them. The interrupt enable flag is cleared by hardware when an interrupt is taken, and it is set again on interrupt return. Instructions can also set or clear it directly.

The transfer bit supports single-bit copies. A store copies a selected bit of an operand byte into the transfer bit. A load returns the operand byte with the selected bit replaced by the transfer bit. Saving and restoring the flags around interrupts is left to software.

Top module: `status_flag_unit`

## Requirements
- R1: After reset all eight flag bits read 0.
- R2: Bit 4 (sign) always equals bit 2 (negative) XOR bit 3 (overflow). Any sign value supplied by the execution unit or by an I/O write is ignored.
- R3: When `alu_we` is high and no I/O write occurs, each flag bit whose `alu_mask` bit is 1 takes the matching `alu_flags` bit. Every other bit keeps its value. Bit 7 is interrupt enable, bit 6 is transfer, bit 5 is half carry, bit 3 is overflow, bit 2 is negative, bit 1 is zero and bit 0 is carry.
- R4: `irq_enter` clears bit 7 on the next edge. It wins over every other source, including an I/O write in the same cycle.
- R5: Without `irq_enter`, either `irq_return` or `gie_set` sets bit 7. `gie_clr` alone clears bit 7. If a set strobe and `gie_clr` arrive together, the set wins.
- R6: `tstore_en` loads bit 6 with bit `bit_sel` of `reg_byte`. This takes priority over I/O and execution-unit writes to bit 6.
- R7: `ld_byte` always equals `reg_byte` with bit `bit_sel` replaced by the current bit 6.
- R8: `io_we` loads all bits from `io_wdata`, with bit 4 forced as in R2. An I/O write overrides a simultaneous execution-unit update.
- R9: With no strobe active, the flags hold their value, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_we | input | 1 | Execution-unit flag update strobe |
| alu_mask | input | 8 | Per-flag update enable |
| alu_flags | input | 8 | Flag values from the execution unit |
| irq_enter | input | 1 | Interrupt taken |
| irq_return | input | 1 | Return from interrupt |
| gie_set | input | 1 | Set interrupt enable |
| gie_clr | input | 1 | Clear interrupt enable |
| tstore_en | input | 1 | Copy selected operand bit into transfer bit |
| reg_byte | input | 8 | Operand byte for bit store and bit load |
| bit_sel | input | 3 | Bit index for bit store and bit load |
| io_we | input | 1 | Byte-wide register write |
| io_wdata | input | 8 | Data for byte-wide write |
| flags | output | 8 | Current flag byte (also the I/O read value) |
| ld_byte | output | 8 | Operand byte with transfer bit inserted |

## Verification
Masked updates are driven from several starting values. The masks cover all bits, a nibble, a single bit and no bits, which separates correct masking from a whole-byte load or a missed update. Some vectors flip only negative or only overflow, to show that the sign flag is recomputed instead of copied from the execution unit. Directed cases put competing strobes in the same cycle to pin down each priority: interrupt entry against an I/O write, set against clear, and I/O against the execution unit. Bit load is tried with both transfer values at different bit positions.

// File: rtl/status_flag_unit.sv
module status_flag_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alu_we,
  input  logic [W-1:0] alu_mask,
  input  logic [W-1:0] alu_flags,
  input  logic         irq_enter,
  input  logic         irq_return,
  input  logic         gie_set,
  input  logic         gie_clr,
  input  logic         tstore_en,
  input  logic [W-1:0] reg_byte,
  input  logic [2:0]   bit_sel,
  input  logic         io_we,
  input  logic [W-1:0] io_wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] ld_byte
);
  localparam int FI = 7, FT = 6, FS = 4, FV = 3, FN = 2;

  logic [W-1:0] st_q, nx;

  always_comb begin
    nx = st_q;
    if (io_we)       nx = io_wdata;
    else if (alu_we) nx = (st_q & ~alu_mask) | (alu_flags & alu_mask);
    if (tstore_en)   nx[FT] = reg_byte[bit_sel];
    if (irq_enter)                  nx[FI] = 1'b0;
    else if (irq_return || gie_set) nx[FI] = 1'b1;
    else if (gie_clr)               nx[FI] = 1'b0;
    nx[FS] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= '0;
    else        st_q <= nx;

  assign flags = {st_q[W-1:FS+1], st_q[FN] ^ st_q[FV], st_q[FS-1:0]};

  always_comb begin
    ld_byte = reg_byte;
    ld_byte[bit_sel] = flags[FT];
  end
endmodule

// File: rtl/status_flag_unit_chk.sv
module status_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alu_we,
  input logic       irq_enter,
  input logic       irq_return,
  input logic       gie_set,
  input logic       gie_clr,
  input logic       tstore_en,
  input logic [7:0] reg_byte,
  input logic [2:0] bit_sel,
  input logic       io_we,
  input logic [7:0] flags,
  input logic [7:0] ld_byte
);
  // R2
  sign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] == (flags[2] ^ flags[3]));
  // R4
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> !flags[7]);
  // R5
  gie_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_enter && (gie_set || irq_return)) |=> flags[7]);
  // R6
  tcopy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tstore_en |=> flags[6] == $past(reg_byte[bit_sel]));
  // R7
  bload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_byte[bit_sel] == flags[6]);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(alu_we || irq_enter || irq_return || gie_set || gie_clr || tstore_en || io_we)
      |=> $stable(flags));
endmodule

bind status_flag_unit status_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .irq_enter(irq_enter),
  .irq_return(irq_return), .gie_set(gie_set), .gie_clr(gie_clr),
  .tstore_en(tstore_en), .reg_byte(reg_byte), .bit_sel(bit_sel),
  .io_we(io_we), .flags(flags), .ld_byte(ld_byte)
);

// File: tb/tb_status_flag_unit.sv
module tb_status_flag_unit;
  localparam int CLK_PER = 10;

  logic clk = 0, rst_n = 0;
  logic alu_we = 0, irq_enter = 0, irq_return = 0, gie_set = 0, gie_clr = 0;
  logic tstore_en = 0, io_we = 0;
  logic [7:0] alu_mask = 0, alu_flags = 0, reg_byte = 0, io_wdata = 0;
  logic [2:0] bit_sel = 0;
  logic [7:0] flags, ld_byte;
  int n_chk = 0, n_bad = 0;

  status_flag_unit dut (.*);

  always #(CLK_PER/2) clk = ~clk;

  // {preload, mask, alu value, expected}
  localparam logic [31:0] VEC [8] = '{
    32'h00_FF_0C_0C, 32'h00_0F_FF_0F, 32'hFF_01_00_EE, 32'h00_04_04_14,
    32'h08_08_00_00, 32'h00_E0_E0_E0, 32'hA5_00_FF_B5, 32'h3C_02_02_2E };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_we = 0; irq_enter = 0; irq_return = 0; gie_set = 0; gie_clr = 0;
    tstore_en = 0; io_we = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic io_load(input logic [7:0] v);
    io_we = 1; io_wdata = v; tick();
  endtask

  initial begin
    #(CLK_PER*100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset", flags, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R3 / R2 masked update table
    for (int i = 0; i < 8; i++) begin
      io_load(VEC[i][31:24]);
      alu_we = 1; alu_mask = VEC[i][23:16]; alu_flags = VEC[i][15:8];
      tick();
      check($sformatf("R3 vec %0d", i), flags, VEC[i][7:0]);
    end

    io_load(8'h10);
    check("R8 sign forced", flags, 8'h00);
    io_load(8'h04);
    check("R2 sign from N", flags, 8'h14);

    io_we = 1; io_wdata = 8'h21; alu_we = 1; alu_mask = 8'hFF; alu_flags = 8'h02;
    tick();
    check("R8 io beats alu", flags, 8'h21);

    alu_we = 0; alu_flags = 8'hFF; reg_byte = 8'hFF; io_wdata = 8'h00;
    tick();
    check("R9 hold", flags, 8'h21);

    io_load(8'h00);
    gie_set = 1; tick();
    check("R5 set", flags, 8'h80);
    gie_clr = 1; tick();
    check("R5 clear", flags, 8'h00);
    irq_return = 1; tick();
    check("R5 return", flags, 8'h80);
    gie_clr = 1; gie_set = 1; tick();
    check("R5 set wins", flags, 8'h80);
    irq_enter = 1; io_we = 1; io_wdata = 8'h81; gie_set = 1; tick();
    check("R4 entry wins", flags, 8'h01);

    io_load(8'h00);
    reg_byte = 8'h40; bit_sel = 3'd6; tstore_en = 1;
    io_we = 1; io_wdata = 8'h00; tick();
    check("R6 store", flags, 8'h40);
    reg_byte = 8'h00; bit_sel = 3'd3; #1;
    check("R7 load one", ld_byte, 8'h08);
    reg_byte = 8'hBF; bit_sel = 3'd6; tstore_en = 1; tick();
    check("R6 store zero", flags, 8'h00);
    reg_byte = 8'hFF; bit_sel = 3'd0; #1;
    check("R7 load zero", ld_byte, 8'hFE);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule